// File: doc/BRIEF.md
# Time-of-Day Update Counter

This block keeps hours, minutes and seconds. Each pulse on a one-hertz tick input starts an update cycle. A flag marks the cycle as busy for a fixed number of clock cycles. Then the time advances by one second, and the block emits a one-cycle update-ended pulse. Software reaches the time bytes and a control byte through a small address/data bus. Reads are combinational.

Software sets the time by first raising a freeze bit in the control byte. This bit cancels any update cycle in progress and stops all further updates. While it is set, the three time bytes accept writes. Clearing the bit lets the clock run again. Two more control bits choose the counting format and the hour format. The format is either packed BCD or plain binary. The hour format is 24-hour, or 12-hour with a PM flag in the top bit of the hour byte. Changing a mode bit does not convert the stored bytes. Software rewrites them while frozen.

Top module: `tod_clock`

## Requirements
- R1: After reset the seconds (address 0), minutes (address 1) and hours (address 2) read 0x00. The control byte (address 3) reads 0x02. The status byte (address 4) reads 0x00, and the update-ended output is low.
- R2: A tick while running sets the update-in-progress flag (status bit 7, also output `uip_o`) for exactly LEAD clock cycles. The time bytes change at the same clock edge at which the flag falls.
- R3: `upd_end_o` is high for exactly one cycle, and that cycle is the first one in which the update-in-progress flag is low again after a completed update.
- R4: The freeze bit is control bit 7. Setting it to 1 drops the flag one cycle later and cancels an update in flight, with no time change and no update-ended pulse. Ticks start nothing while the bit is 1.
- R5: A write to a time byte stores the written value only while the freeze bit is 1. While the bit is 0, the write leaves the byte unchanged. The control byte is always writable.
- R6: In BCD mode (control bit 2 = 0), seconds and minutes step with a decimal carry (0x19 becomes 0x20). They wrap from 0x59 to 0x00 and carry into the next field.
- R7: In binary mode (control bit 2 = 1), seconds and minutes step by one and wrap from 59 to 0 with a carry.
- R8: In 24-hour mode (control bit 1 = 1), hours wrap from 23 to 0. In BCD mode the wrap is from 0x23 to 0x00.
- R9: In 12-hour mode (control bit 1 = 0), hour-byte bit 7 is the PM flag. Hours run 12, 1, …, 11. The step from 11 to 12 toggles PM, and 12 steps to 1 with PM kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| uip_o | output | 1 | Update in progress |
| upd_end_o | output | 1 | Update-ended pulse |

## Verification
On every cycle, the assertions check the following. The update-ended pulse lasts one cycle and comes only as the busy flag falls. The freeze bit kills the flag and the pulse. The time bytes hold still whenever no update or write is under way. A write made while frozen lands exactly. Only the bench scenarios can show the count of LEAD busy cycles and the arithmetic itself. That covers decimal and binary carries, the wrap at 59 and at 23, and the 12-hour PM sequence.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int unsigned ADDR_SEC  = 0;
    localparam int unsigned ADDR_MIN  = 1;
    localparam int unsigned ADDR_HR   = 2;
    localparam int unsigned ADDR_CTRL = 3;
    localparam int unsigned ADDR_STAT = 4;

    localparam int unsigned CTRL_FREEZE = 7;
    localparam int unsigned CTRL_BINARY = 2;
    localparam int unsigned CTRL_H24    = 1;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hr;
        logic       freeze;
        logic       binary;
        logic       h24;
    } tod_regs_t;

    // Increment by one in binary, or as two packed BCD digits
    function automatic logic [7:0] bump(input logic [7:0] v, input logic bin);
        if (bin)
            return v + 8'd1;
        else if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/tod_field_step.sv
module tod_field_step
    import tod_pkg::*;
#(
    parameter int unsigned LAST = 59
) (
    input  logic [7:0] val_i,
    input  logic       binary_i,
    output logic [7:0] nxt_o,
    output logic       wrap_o
);
    localparam logic [7:0] LAST_BIN = 8'(LAST);
    localparam logic [7:0] LAST_BCD = 8'(((LAST / 10) << 4) | (LAST % 10));

    always_comb begin
        wrap_o = binary_i ? (val_i == LAST_BIN) : (val_i == LAST_BCD);
        nxt_o  = wrap_o ? 8'd0 : bump(val_i, binary_i);
    end
endmodule

// File: rtl/tod_hour_step.sv
module tod_hour_step
    import tod_pkg::*;
(
    input  logic [7:0] val_i,
    input  logic       binary_i,
    input  logic       h24_i,
    output logic [7:0] nxt_o
);
    logic [7:0] last24;
    logic [6:0] eleven;
    logic [6:0] twelve;
    logic [7:0] h_inc;

    always_comb begin
        last24 = binary_i ? 8'd23 : 8'h23;
        eleven = binary_i ? 7'd11 : 7'h11;
        twelve = binary_i ? 7'd12 : 7'h12;
        h_inc  = bump({1'b0, val_i[6:0]}, binary_i);
        if (h24_i)
            nxt_o = (val_i == last24) ? 8'd0 : bump(val_i, binary_i);
        else if (val_i[6:0] == twelve)
            nxt_o = {val_i[7], 7'd1};
        else if (val_i[6:0] == eleven)
            nxt_o = {~val_i[7], twelve};
        else
            nxt_o = {val_i[7], h_inc[6:0]};
    end
endmodule

// File: rtl/tod_seq.sv
module tod_seq #(
    parameter int unsigned LEAD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic freeze_i,
    output logic busy_o,
    output logic fire_o,
    output logic done_o
);
    localparam int unsigned CNT_W = $clog2(LEAD + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (freeze_i) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (tick_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(LEAD - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign fire_o = st_q.busy && (st_q.cnt == '0) && !freeze_i;
    assign done_o = st_q.done;
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int unsigned LEAD   = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              uip_o,
    output logic              upd_end_o
);
    tod_regs_t regs_d, regs_q;
    logic       fire;
    logic [7:0] sec_nxt, min_nxt, hr_nxt;
    logic       sec_wrap, min_wrap;

    tod_seq #(.LEAD(LEAD)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_1hz),
        .freeze_i(regs_q.freeze),
        .busy_o  (uip_o),
        .fire_o  (fire),
        .done_o  (upd_end_o)
    );

    tod_field_step #(.LAST(59)) u_sec (
        .val_i(regs_q.sec), .binary_i(regs_q.binary),
        .nxt_o(sec_nxt), .wrap_o(sec_wrap)
    );

    tod_field_step #(.LAST(59)) u_min (
        .val_i(regs_q.min), .binary_i(regs_q.binary),
        .nxt_o(min_nxt), .wrap_o(min_wrap)
    );

    tod_hour_step u_hr (
        .val_i(regs_q.hr), .binary_i(regs_q.binary),
        .h24_i(regs_q.h24), .nxt_o(hr_nxt)
    );

    always_comb begin
        regs_d = regs_q;
        if (fire) begin
            regs_d.sec = sec_nxt;
            if (sec_wrap)             regs_d.min = min_nxt;
            if (sec_wrap && min_wrap) regs_d.hr  = hr_nxt;
        end
        if (bus_we) begin
            if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
                regs_d.freeze = bus_wdata[CTRL_FREEZE];
                regs_d.binary = bus_wdata[CTRL_BINARY];
                regs_d.h24    = bus_wdata[CTRL_H24];
            end else if (regs_q.freeze) begin
                if (bus_addr == ADDR_W'(ADDR_SEC)) regs_d.sec = bus_wdata;
                if (bus_addr == ADDR_W'(ADDR_MIN)) regs_d.min = bus_wdata;
                if (bus_addr == ADDR_W'(ADDR_HR))  regs_d.hr  = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.h24 <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == ADDR_W'(ADDR_SEC))  bus_rdata = regs_q.sec;
        if (bus_addr == ADDR_W'(ADDR_MIN))  bus_rdata = regs_q.min;
        if (bus_addr == ADDR_W'(ADDR_HR))   bus_rdata = regs_q.hr;
        if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
            bus_rdata[CTRL_FREEZE] = regs_q.freeze;
            bus_rdata[CTRL_BINARY] = regs_q.binary;
            bus_rdata[CTRL_H24]    = regs_q.h24;
        end
        if (bus_addr == ADDR_W'(ADDR_STAT)) bus_rdata[7] = uip_o;
    end
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk #(
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              uip_o,
    input logic              upd_end_o,
    input logic              freeze,
    input logic [23:0]       tod
);
    // R3: the pulse arrives as the busy flag falls
    a_r3_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        upd_end_o |-> (!uip_o && $past(uip_o)));

    // R3: the pulse lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        upd_end_o |=> !upd_end_o);

    // R4: freeze clears the busy flag
    a_r4_freeze_kills_uip: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !uip_o);

    // R4: freeze blocks the update-ended pulse
    a_r4_freeze_no_end: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !upd_end_o);

    // R2: the time holds still outside an update cycle and without a write
    a_r2_time_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip_o && !bus_we) |=> $stable(tod));

    // R5: writes made while running leave the time alone
    a_r5_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !freeze && !uip_o) |=> $stable(tod));

    // R5: a frozen write to the seconds byte lands exactly
    a_r5_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && freeze && bus_addr == ADDR_W'(0)) |=> (tod[23:16] == $past(bus_wdata)));
endmodule

bind tod_clock tod_clock_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .uip_o    (uip_o),
    .upd_end_o(upd_end_o),
    .freeze   (regs_q.freeze),
    .tod      ({regs_q.sec, regs_q.min, regs_q.hr})
);

// File: tb/test_tod_clock.sv
module test_tod_clock;
    localparam int LEAD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       uip_o, upd_end_o;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tod_clock #(.LEAD(LEAD), .ADDR_W(3)) i_tod_clock (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .uip_o(uip_o), .upd_end_o(upd_end_o)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic pulse_tick;
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic step_one;
        pulse_tick();
        repeat (LEAD + 2) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m,
                            input logic [7:0] s, input logic [7:0] ctrl);
        wr(3'd3, ctrl | 8'h80);
        wr(3'd0, s);
        wr(3'd1, m);
        wr(3'd2, h);
        wr(3'd3, ctrl);
    endtask

    task automatic check_time(input string req, input logic [7:0] h,
                              input logic [7:0] m, input logic [7:0] s);
        logic [7:0] v;
        rd(3'd0, v); check({req, " sec"}, v, s);
        rd(3'd1, v); check({req, " min"}, v, m);
        rd(3'd2, v); check({req, " hour"}, v, h);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check_time("R1", 8'h00, 8'h00, 8'h00);
        rd(3'd3, v); check("R1 ctrl", v, 8'h02);
        rd(3'd4, v); check("R1 status", v, 8'h00);
        check("R1 upd_end", {7'd0, upd_end_o}, 8'h00);
    endtask

    task automatic t_write_ignored;
        wr(3'd0, 8'h33);
        wr(3'd2, 8'h07);
        check_time("R5 ignored", 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_uip_timing;
        int n;
        logic [7:0] v;
        set_time(8'h05, 8'h10, 8'h19, 8'h02);
        pulse_tick();
        n = 0;
        rd(3'd4, v);
        check("R2 status uip", v, 8'h80);
        while (uip_o && n < 100) begin
            rd(3'd0, v);
            check("R2 sec held", v, 8'h19);
            n++;
            @(negedge clk);
        end
        check("R2 uip cycles", 8'(n), 8'(LEAD));
        check("R3 pulse at fall", {7'd0, upd_end_o}, 8'h01);
        rd(3'd0, v); check("R6 bcd 19->20", v, 8'h20);
        @(negedge clk);
        check("R3 one cycle", {7'd0, upd_end_o}, 8'h00);
    endtask

    task automatic t_bcd_carry;
        set_time(8'h05, 8'h09, 8'h59, 8'h02);
        step_one();
        check_time("R6 carry", 8'h05, 8'h10, 8'h00);
        set_time(8'h23, 8'h59, 8'h59, 8'h02);
        step_one();
        check_time("R8 bcd wrap", 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_binary;
        set_time(8'd23, 8'd59, 8'd59, 8'h06);
        step_one();
        check_time("R7 R8 binary wrap", 8'd0, 8'd0, 8'd0);
        set_time(8'd3, 8'd9, 8'd9, 8'h06);
        step_one();
        check_time("R7 binary step", 8'd3, 8'd9, 8'd10);
    endtask

    task automatic t_12h;
        set_time(8'h11, 8'h59, 8'h59, 8'h00);
        step_one();
        check_time("R9 11am->12pm", 8'h92, 8'h00, 8'h00);
        set_time(8'h92, 8'h59, 8'h59, 8'h00);
        step_one();
        check_time("R9 12pm->1pm", 8'h81, 8'h00, 8'h00);
        set_time(8'h91, 8'h59, 8'h59, 8'h00);
        step_one();
        check_time("R9 11pm->12am", 8'h12, 8'h00, 8'h00);
        set_time(8'd11, 8'd59, 8'd59, 8'h04);
        step_one();
        check_time("R9 binary 12h", 8'h8C, 8'd0, 8'd0);
    endtask

    task automatic t_abort;
        int seen;
        set_time(8'h01, 8'h02, 8'h03, 8'h02);
        pulse_tick();
        repeat (3) @(negedge clk);
        check("R4 busy before freeze", {7'd0, uip_o}, 8'h01);
        wr(3'd3, 8'h82);
        @(negedge clk);
        check("R4 uip dropped", {7'd0, uip_o}, 8'h00);
        seen = 0;
        tick_1hz = 1'b1;
        for (int i = 0; i < LEAD + 6; i++) begin
            @(negedge clk);
            tick_1hz = 1'b0;
            if (upd_end_o || uip_o) seen++;
        end
        check("R4 no pulse or busy while frozen", 8'(seen), 8'd0);
        check_time("R4 time kept", 8'h01, 8'h02, 8'h03);
        wr(3'd0, 8'h45);
        check_time("R5 frozen write", 8'h01, 8'h02, 8'h45);
        wr(3'd3, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_ignored();
        t_uip_timing();
        t_bcd_carry();
        t_binary();
        t_12h();
        t_abort();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule